// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Controller

This block gathers up to 64 interrupt sources into a bank of parent interrupt lines. Each source is set per bit as level sensitive or edge sensitive, and each source can be masked on its own. The block holds four per-source bit vectors: pending requests, in-service flags, the last input level seen, and the edge-select configuration. It also holds one 8-bit vector entry per source, and that entry names the parent line the source drives.

Input changes arrive as events. An event is a valid flag and a level for each source. The block takes one event per cycle, always the lowest-numbered valid source first, and returns a one-hot ready to the source it took. A rising event runs the assertion rule on that source. A falling event runs the deassertion rule. Software reaches the block through a one-cycle configuration write port with four operations: mask, edge-select, edge-clear and vector-entry. A combinational status vector shows the in-service sources that are not masked. Parent lines are registered levels.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the request, in-service, last-level, edge-select and vector-entry state is zero, all parent outputs are low, and every mask bit is 1. While its mask bit is 1, a source that raises its input drives no parent output.
- R2: For a level source (edge-select bit 0), the request bit and the stored last level follow the event level. A falling event on an in-service level source clears its in-service bit and drives its mapped parent output low.
- R3: For an edge source (edge-select bit 1), a request is latched only when a high event arrives while the stored last level is 0. A low event updates only the stored last level. The request, and with it the in-service bit and the parent output, stays set until an edge-clear write.
- R4: On a high event, if the source's request is set and its mask bit is 0, the block sets its in-service bit and drives parent output number vector[source] high in the next cycle.
- R5: A mask write (op code 0) replaces the whole mask with the data. Of the bits that go from 1 to 0 and have a pending request, only the lowest-numbered one gets the assertion rule. Of the bits that go from 0 to 1, the lowest one that is in service and has no request gets the deassertion rule.
- R6: An edge-clear write (op code 2) acts only when its data overlaps the edge-select bits. When it acts, it clears the requests under the data, drives low the parent of the lowest such in-service source, and clears all in-service bits under the data. When there is no overlap, it changes nothing.
- R7: The status output equals the in-service vector ANDed with the inverted mask.
- R8: An edge-select write (op code 1) replaces the edge-select vector. A vector write (op code 3) stores data bits [7:0] as the entry for the source at cfg_idx_i. The entry is used as the parent index, 0 to 255.
- R9: When several events are valid, ready is one-hot on the lowest valid source. Sources are served in ascending order, one per cycle. While cfg_we_i is high, all ready bits are low.
- R10: Parent outputs change only in the cycle after an accepted event or a configuration write. A falling event clears its mapped parent line even when another in-service source shares that line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_vld_i | input | 64 | Per-source event valid |
| evt_lvl_i | input | 64 | Per-source new input level |
| evt_rdy_o | output | 64 | One-hot event accept |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | 0 mask, 1 edge-select, 2 edge-clear, 3 vector entry |
| cfg_idx_i | input | 6 | Source index for vector writes |
| cfg_data_i | input | 64 | Write data |
| stat_o | output | 64 | In-service and not masked |
| par_o | output | 256 | Parent interrupt lines |

## Verification
The hardest situation to reach is a mask write that unmasks several sources that already hold requests. Only the lowest of them may reach its parent. Reaching it means raising level inputs on sources that are still masked after reset, then clearing the whole mask in a single write. A second hard case is an edge source that is already high and sees another high event after an edge-clear. It must not latch a new request. The bench reaches this by sending a repeated high event with no falling event in between.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic [1:0] {
    OP_MASK  = 2'd0,
    OP_EDGE  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_VEC   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/lowbit_enc.sv
module lowbit_enc #(
  parameter int W   = 64,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_table.sv
module vec_table #(
  parameter int N     = 64,
  parameter int VEC_W = 8,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IW-1:0]    widx_i,
  input  logic [VEC_W-1:0] wdata_i,
  input  logic [IW-1:0]    ra_i,
  input  logic [IW-1:0]    rb_i,
  output logic [VEC_W-1:0] qa_o,
  output logic [VEC_W-1:0] qb_o
);
  logic [VEC_W-1:0] tbl_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         tbl_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))   tbl_q[g] <= wdata_i;
    end
  end

  assign qa_o = tbl_q[ra_i];
  assign qb_o = tbl_q[rb_i];
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int VEC_W  = 8,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int N_PAR = 1 << VEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  evt_vld_i,
  input  logic [N_SRC-1:0]  evt_lvl_i,
  output logic [N_SRC-1:0]  evt_rdy_o,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_op_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [N_SRC-1:0]  cfg_data_i,
  output logic [N_SRC-1:0]  stat_o,
  output logic [N_PAR-1:0]  par_o
);
  logic [N_SRC-1:0] req_q, isr_q, last_q, edge_q, msk_q;
  logic [N_SRC-1:0] req_n, isr_n, last_n, edge_n, msk_n;
  logic [N_PAR-1:0] par_q, par_n;
  logic [N_SRC-1:0] a_vec, d_vec, isr_wipe, evt_bit;
  logic [IDX_W-1:0] evt_idx, a_idx, d_idx;
  logic             evt_any, evt_go, evt_lvl, a_any, d_any;
  logic [VEC_W-1:0] a_par, d_par;
  cfg_op_e          op;

  assign op = cfg_op_e'(cfg_op_i);

  lowbit_enc #(.W(N_SRC)) u_evt_enc (.vec_i(evt_vld_i), .any_o(evt_any), .idx_o(evt_idx));

  // config writes take the cycle; events wait
  assign evt_go    = evt_any && !cfg_we_i;
  assign evt_bit   = {{(N_SRC-1){1'b0}}, 1'b1} << evt_idx;
  assign evt_rdy_o = evt_go ? evt_bit : '0;
  assign evt_lvl   = evt_lvl_i[evt_idx];

  always_comb begin
    req_n    = req_q;
    last_n   = last_q;
    msk_n    = msk_q;
    edge_n   = edge_q;
    a_vec    = '0;
    d_vec    = '0;
    isr_wipe = '0;
    if (cfg_we_i) begin
      unique case (op)
        OP_MASK: begin
          msk_n = cfg_data_i;
          a_vec = msk_q & ~cfg_data_i & req_q;
          d_vec = ~msk_q & cfg_data_i & isr_q & ~req_q;
        end
        OP_EDGE: edge_n = cfg_data_i;
        OP_CLEAR: begin
          if (|(edge_q & cfg_data_i)) begin
            req_n    = req_q & ~cfg_data_i;
            d_vec    = cfg_data_i & isr_q & ~req_n;
            isr_wipe = cfg_data_i;
          end
        end
        default: ;
      endcase
    end else if (evt_go) begin
      if (edge_q[evt_idx]) begin
        if (evt_lvl) begin
          if (!last_q[evt_idx]) req_n = req_q | evt_bit;
          last_n = last_q | evt_bit;
        end else begin
          last_n = last_q & ~evt_bit;
        end
      end else if (evt_lvl) begin
        req_n  = req_q | evt_bit;
        last_n = last_q | evt_bit;
      end else begin
        req_n  = req_q & ~evt_bit;
        last_n = last_q & ~evt_bit;
      end
      if (evt_lvl) a_vec = evt_bit & req_n & ~msk_q;
      else         d_vec = evt_bit & isr_q & ~req_n;
    end
  end

  lowbit_enc #(.W(N_SRC)) u_a_enc (.vec_i(a_vec), .any_o(a_any), .idx_o(a_idx));
  lowbit_enc #(.W(N_SRC)) u_d_enc (.vec_i(d_vec), .any_o(d_any), .idx_o(d_idx));

  vec_table #(.N(N_SRC), .VEC_W(VEC_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && op == OP_VEC),
    .widx_i  (cfg_idx_i),
    .wdata_i (cfg_data_i[VEC_W-1:0]),
    .ra_i    (a_idx),
    .rb_i    (d_idx),
    .qa_o    (a_par),
    .qb_o    (d_par)
  );

  // assertion applied before deassertion; the clear wipe comes last
  always_comb begin
    isr_n = isr_q;
    par_n = par_q;
    if (a_any) begin
      isr_n[a_idx] = 1'b1;
      par_n[a_par] = 1'b1;
    end
    if (d_any) begin
      isr_n[d_idx] = 1'b0;
      par_n[d_par] = 1'b0;
    end
    isr_n = isr_n & ~isr_wipe;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      isr_q  <= '0;
      last_q <= '0;
      edge_q <= '0;
      msk_q  <= '1;
      par_q  <= '0;
    end else begin
      req_q  <= req_n;
      isr_q  <= isr_n;
      last_q <= last_n;
      edge_q <= edge_n;
      msk_q  <= msk_n;
      par_q  <= par_n;
    end
  end

  assign stat_o = isr_q & ~msk_q;
  assign par_o  = par_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int N_SRC = 64,
  parameter int N_PAR = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] evt_vld_i,
  input logic [N_SRC-1:0] evt_lvl_i,
  input logic [N_SRC-1:0] evt_rdy_o,
  input logic             cfg_we_i,
  input logic [1:0]       cfg_op_i,
  input logic [N_SRC-1:0] cfg_data_i,
  input logic [N_PAR-1:0] par_o,
  input logic [N_SRC-1:0] req_q,
  input logic [N_SRC-1:0] isr_q,
  input logic [N_SRC-1:0] edge_q
);
  logic acc_any, acc_rise, acc_edge_fall;
  assign acc_any       = |(evt_vld_i & evt_rdy_o);
  assign acc_rise      = |(evt_vld_i & evt_rdy_o & evt_lvl_i);
  assign acc_edge_fall = |(evt_vld_i & evt_rdy_o & ~evt_lvl_i & edge_q);

  // R9
  rdy_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evt_rdy_o) && ((evt_rdy_o & ~evt_vld_i) == '0));

  // R9
  cfg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |-> (evt_rdy_o == '0));

  // R10
  par_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && !acc_any) |=> $stable(par_o));

  // R3
  edge_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_edge_fall |=> $stable(req_q));

  // R4
  isr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(cfg_we_i && cfg_op_i == 2'd0) && !acc_rise) |=> ((isr_q & ~$past(isr_q)) == '0));

  // R6
  clr_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_op_i == 2'd2 && |(edge_q & cfg_data_i)) |=> ((isr_q & $past(cfg_data_i)) == '0));
endmodule

bind irq_pend_ctrl irq_pend_chk #(.N_SRC(N_SRC), .N_PAR(N_PAR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_vld_i  (evt_vld_i),
  .evt_lvl_i  (evt_lvl_i),
  .evt_rdy_o  (evt_rdy_o),
  .cfg_we_i   (cfg_we_i),
  .cfg_op_i   (cfg_op_i),
  .cfg_data_i (cfg_data_i),
  .par_o      (par_o),
  .req_q      (req_q),
  .isr_q      (isr_q),
  .edge_q     (edge_q)
);

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [63:0]  evt_vld = '0, evt_lvl = '0, cfg_data = '0;
  logic [63:0]  evt_rdy, stat;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_op = '0;
  logic [5:0]   cfg_idx = '0;
  logic [255:0] par;
  int           n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  irq_pend_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_vld_i(evt_vld), .evt_lvl_i(evt_lvl),
    .evt_rdy_o(evt_rdy), .cfg_we_i(cfg_we), .cfg_op_i(cfg_op), .cfg_idx_i(cfg_idx),
    .cfg_data_i(cfg_data), .stat_o(stat), .par_o(par)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] b(input int i);
    return 64'd1 << i;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; evt_vld = '0; evt_lvl = '0; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [1:0] op, input int idx, input logic [63:0] d);
    cfg_we = 1'b1; cfg_op = op; cfg_idx = 6'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic evt(input int src, input logic lvl);
    evt_vld[src] = 1'b1; evt_lvl[src] = lvl;
    @(negedge clk);
    evt_vld[src] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 par after reset", 64'(|par), 64'd0);
    chk("R7 stat after reset", stat, '0);
    evt(3, 1'b1);
    chk("R1 masked source drives nothing", 64'(par[0]), 64'd0);
    chk("R7 masked stat", stat, '0);
    cfg_wr(2'd0, 0, '0);
    chk("R5 unmask asserts pending", 64'(par[0]), 64'd1);
    chk("R7 stat after unmask", stat, b(3));
  endtask

  task automatic t_level();
    do_reset();
    cfg_wr(2'd0, 0, '0);
    cfg_wr(2'd3, 5, 64'd7);
    evt(5, 1'b1);
    chk("R4 level rise par7", 64'(par[7]), 64'd1);
    chk("R8 only mapped line", 64'(par[0]), 64'd0);
    evt(5, 1'b0);
    chk("R2 level fall par7", 64'(par[7]), 64'd0);
    chk("R2 level fall stat", stat, '0);
  endtask

  task automatic t_edge();
    do_reset();
    cfg_wr(2'd0, 0, '0);
    cfg_wr(2'd1, 0, b(9));
    cfg_wr(2'd3, 9, 64'd20);
    evt(9, 1'b1);
    chk("R3 edge rise par20", 64'(par[20]), 64'd1);
    evt(9, 1'b0);
    chk("R3 edge fall keeps par20", 64'(par[20]), 64'd1);
    chk("R3 edge fall keeps stat", stat, b(9));
    cfg_wr(2'd2, 0, b(9));
    chk("R6 clear drops par20", 64'(par[20]), 64'd0);
    chk("R6 clear drops stat", stat, '0);
    evt(9, 1'b1);
    chk("R3 new rise latches", 64'(par[20]), 64'd1);
    cfg_wr(2'd2, 0, b(9));
    evt(9, 1'b1);
    chk("R3 high while last high ignored", 64'(par[20]), 64'd0);
    chk("R3 stat stays clear", stat, '0);
  endtask

  task automatic t_clear_level();
    do_reset();
    cfg_wr(2'd0, 0, '0);
    cfg_wr(2'd3, 2, 64'd4);
    evt(2, 1'b1);
    cfg_wr(2'd2, 0, b(2));
    chk("R6 clear on level ignored par", 64'(par[4]), 64'd1);
    chk("R6 clear on level ignored stat", stat, b(2));
  endtask

  task automatic t_mask();
    do_reset();
    cfg_wr(2'd3, 10, 64'd1);
    cfg_wr(2'd3, 12, 64'd2);
    evt(10, 1'b1);
    evt(12, 1'b1);
    cfg_wr(2'd0, 0, '0);
    chk("R5 lowest unmasked gets par1", 64'(par[1]), 64'd1);
    chk("R5 higher stays off par2", 64'(par[2]), 64'd0);
    chk("R5 stat lowest only", stat, b(10));
    cfg_wr(2'd0, 0, b(10));
    chk("R5 mask with request keeps par1", 64'(par[1]), 64'd1);
    chk("R7 masked in-service hidden", stat, '0);
    evt(10, 1'b0);
    chk("R2 fall while masked clears par1", 64'(par[1]), 64'd0);
  endtask

  task automatic t_arb();
    do_reset();
    cfg_wr(2'd0, 0, '0);
    cfg_wr(2'd3, 20, 64'd5);
    cfg_wr(2'd3, 15, 64'd6);
    evt_vld[15] = 1'b1; evt_lvl[15] = 1'b1;
    evt_vld[20] = 1'b1; evt_lvl[20] = 1'b1;
    #1 chk("R9 lowest ready first", evt_rdy, b(15));
    @(negedge clk);
    chk("R9 first served par6", 64'(par[6]), 64'd1);
    chk("R9 second waits par5", 64'(par[5]), 64'd0);
    evt_vld[15] = 1'b0;
    #1 chk("R9 next ready", evt_rdy, b(20));
    @(negedge clk);
    evt_vld[20] = 1'b0;
    chk("R9 second served par5", 64'(par[5]), 64'd1);
    evt_vld[40] = 1'b1; evt_lvl[40] = 1'b1;
    cfg_we = 1'b1; cfg_op = 2'd3; cfg_idx = 6'd40; cfg_data = 64'd11;
    #1 chk("R9 config blocks ready", evt_rdy, '0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R10 no par change on vec write", 64'(par[11]), 64'd0);
    #1 chk("R9 ready after config", evt_rdy, b(40));
    @(negedge clk);
    evt_vld[40] = 1'b0;
    chk("R8 new vector used", 64'(par[11]), 64'd1);
  endtask

  task automatic t_share();
    do_reset();
    cfg_wr(2'd0, 0, '0);
    cfg_wr(2'd3, 30, 64'd9);
    cfg_wr(2'd3, 31, 64'd9);
    evt(30, 1'b1);
    evt(31, 1'b1);
    evt(30, 1'b0);
    chk("R10 shared line dropped", 64'(par[9]), 64'd0);
    chk("R7 other still in service", stat, b(31));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_clear_level();
    t_mask();
    t_arb();
    t_share();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule